// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Aggregator

The block collects up to 256 level-sensitive interrupt lines, grouped into 32-bit words, and presents one interrupt output per CPU bank. All banks see the same raw source levels. Each bank holds its own mask bits, so software on different CPUs can route any source to one bank and hide it from the others.

Each bank has a register window of four groups placed back to back. The groups are raw status, mask readback, set-mask and clear-mask. Each group holds one 32-bit register per word. Group offsets therefore scale with the word count `NUM_WORDS`. A plain 32-bit read/write port selects the bank with `bank_i` and the register with the byte offset `offs_i`. Read data is registered and appears on `rdata_o` in the cycle after the request.

Top module: `lvl_irq_fanout`

## Requirements
- R1: After reset every mask bit of every bank is 1, `irq_o` is all zero and `rdata_o` is zero.
- R2: The register index is `offs_i[OFFS_W-1:2]`; byte bits [1:0] are ignored. The group is index / NUM_WORDS and the word is index % NUM_WORDS. Group codes: 0 raw status, 1 mask readback, 2 set-mask, 3 clear-mask.
- R3: A write to the set-mask register of word w sets to 1 every mask bit of that bank and word where `wdata_i` is 1. Other bits are unchanged.
- R4: A write to the clear-mask register of word w clears to 0 every mask bit of that bank and word where `wdata_i` is 1. Other bits are unchanged.
- R5: A bank's pending bits are the raw source levels AND NOT that bank's mask. `irq_o[b]` is the registered OR of all pending bits of bank b. It changes one clock after a source or mask change, and it follows the source level with no latching.
- R6: Mask writes change only the bank selected by `bank_i`. Source levels are shared by all banks.
- R7: A read returns its data on `rdata_o` one clock after the request. `rdata_o` holds that value until the next read. A raw status read returns `src_i` for that word as sampled at the request edge, with no mask applied. A mask readback read returns the current mask word of the selected bank.
- R8: Writes to the raw status or mask readback groups have no effect. Reads of the set-mask or clear-mask groups return zero.
- R9: When the register index is at or above 4 × NUM_WORDS, or `bank_i` is at or above NUM_BANKS, a write has no effect and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32*NUM_WORDS | Raw level-sensitive interrupt sources |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| bank_i | input | BANK_W | CPU bank select |
| offs_i | input | OFFS_W | Byte offset within the bank window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_BANKS | Per-bank parent interrupt |

## Verification
The assertions assume that `src_i` is synchronous to `clk_i` and that the access fields are stable while `req_i` is high. The mask checks also assume that each access targets one decoded word. The bench drives every input half a cycle away from the active edge and leaves an idle cycle between accesses. It changes sources only when no access is in flight, so the effect of each mask write on `irq_o` is seen alone.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int WORD_BITS = 32;
  localparam int MAX_WORDS = 8;

  typedef enum logic [1:0] {
    GRP_RAW      = 2'd0,
    GRP_MASK_RD  = 2'd1,
    GRP_MASK_SET = 2'd2,
    GRP_MASK_CLR = 2'd3
  } grp_e;
endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode #(
  parameter int NUM_WORDS = 2,
  parameter int OFFS_W    = 8,
  localparam int IDX_W    = OFFS_W - 2,
  localparam int WORD_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic [OFFS_W-1:0] offs_i,
  output logic              valid_o,
  output irqagg_pkg::grp_e  grp_o,
  output logic [WORD_W-1:0] word_o
);
  logic [IDX_W-1:0] idx, quo, rem;

  // byte lanes ignored: registers are whole words
  assign idx = offs_i[OFFS_W-1:2];

  always_comb begin
    quo     = idx / IDX_W'(NUM_WORDS);
    rem     = idx % IDX_W'(NUM_WORDS);
    valid_o = idx < IDX_W'(4 * NUM_WORDS);
    grp_o   = irqagg_pkg::grp_e'(quo[1:0]);
    word_o  = rem[WORD_W-1:0];
  end
endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank #(
  parameter int NUM_WORDS = 2,
  localparam int SRC_W    = irqagg_pkg::WORD_BITS * NUM_WORDS,
  localparam int WORD_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_we_i,
  input  logic              clr_we_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [31:0]       wdata_i,
  input  logic [SRC_W-1:0]  src_i,
  output logic [SRC_W-1:0]  mask_o,
  output logic              irq_o
);
  logic [SRC_W-1:0] pend;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit;
    assign hit = (word_i == WORD_W'(w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[w*32 +: 32] <= '1;
      end else if (hit && set_we_i) begin
        mask_o[w*32 +: 32] <= mask_o[w*32 +: 32] | wdata_i;
      end else if (hit && clr_we_i) begin
        mask_o[w*32 +: 32] <= mask_o[w*32 +: 32] & ~wdata_i;
      end
    end
  end

  assign pend = src_i & ~mask_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |pend;
  end
endmodule

// File: rtl/lvl_irq_fanout.sv
module lvl_irq_fanout #(
  parameter int NUM_WORDS = 2,
  parameter int NUM_BANKS = 2,
  parameter int OFFS_W    = 8,
  localparam int SRC_W    = irqagg_pkg::WORD_BITS * NUM_WORDS,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int WORD_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SRC_W-1:0]     src_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [OFFS_W-1:0]    offs_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_BANKS-1:0] irq_o
);
  import irqagg_pkg::*;

  logic                                dec_valid, acc_ok;
  grp_e                                dec_grp;
  logic [WORD_W-1:0]                   dec_word;
  logic [NUM_BANKS-1:0][SRC_W-1:0]     mask_all;
  logic [31:0]                         rd_next;

  irqagg_decode #(.NUM_WORDS(NUM_WORDS), .OFFS_W(OFFS_W)) u_dec (
    .offs_i (offs_i),
    .valid_o(dec_valid),
    .grp_o  (dec_grp),
    .word_o (dec_word)
  );

  assign acc_ok = dec_valid && (int'(bank_i) < NUM_BANKS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = req_i && we_i && acc_ok && (bank_i == BANK_W'(b));
    irqagg_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_we_i(sel && dec_grp == GRP_MASK_SET),
      .clr_we_i(sel && dec_grp == GRP_MASK_CLR),
      .word_i  (dec_word),
      .wdata_i (wdata_i),
      .src_i   (src_i),
      .mask_o  (mask_all[b]),
      .irq_o   (irq_o[b])
    );
  end

  always_comb begin
    rd_next = '0;
    if (acc_ok) begin
      case (dec_grp)
        GRP_RAW:     rd_next = src_i[int'(dec_word)*32 +: 32];
        GRP_MASK_RD: rd_next = mask_all[bank_i][int'(dec_word)*32 +: 32];
        default:     rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= rd_next;
  end
endmodule

// File: rtl/lvl_irq_fanout_chk.sv
module lvl_irq_fanout_chk #(
  parameter int NUM_WORDS = 2,
  parameter int NUM_BANKS = 2,
  parameter int OFFS_W    = 8,
  localparam int SRC_W    = 32 * NUM_WORDS,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int WORD_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [SRC_W-1:0]                src_i,
  input logic                            req_i,
  input logic                            we_i,
  input logic [BANK_W-1:0]               bank_i,
  input logic [31:0]                     wdata_i,
  input logic [31:0]                     rdata_o,
  input logic [NUM_BANKS-1:0]            irq_o,
  input logic                            acc_ok,
  input logic [1:0]                      dec_grp,
  input logic [WORD_W-1:0]               dec_word,
  input logic [NUM_BANKS-1:0][SRC_W-1:0] mask_all
);
  logic              last_set, last_clr;
  logic [BANK_W-1:0] last_bank;
  logic [WORD_W-1:0] last_word;
  logic [31:0]       last_data, last_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_set <= 1'b0; last_clr <= 1'b0;
      last_bank <= '0; last_word <= '0; last_data <= '0;
    end else begin
      last_set  <= req_i && we_i && acc_ok && dec_grp == 2'd2;
      last_clr  <= req_i && we_i && acc_ok && dec_grp == 2'd3;
      last_bank <= bank_i;
      last_word <= dec_word;
      last_data <= wdata_i;
    end
  end

  assign last_mask = mask_all[last_bank][int'(last_word)*32 +: 32];

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_set |-> ((last_mask & last_data) == last_data));

  p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_clr |-> ((last_mask & last_data) == '0));

  p_quiet_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |=> (irq_o == '0));

  p_ro_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && acc_ok && dec_grp[1] == 1'b0) |=> $stable(mask_all));

  p_wo_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && acc_ok && dec_grp[1] == 1'b1) |=> (rdata_o == '0));

  p_oor_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !acc_ok) |=> $stable(mask_all));

  p_oor_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !acc_ok) |=> (rdata_o == '0));

  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(mask_all));
endmodule

bind lvl_irq_fanout lvl_irq_fanout_chk #(
  .NUM_WORDS(NUM_WORDS), .NUM_BANKS(NUM_BANKS), .OFFS_W(OFFS_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .bank_i  (bank_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .acc_ok  (acc_ok),
  .dec_grp (dec_grp),
  .dec_word(dec_word),
  .mask_all(mask_all)
);

// File: tb/sim_lvl_irq_fanout.sv
`timescale 1ns/1ps
module sim_lvl_irq_fanout;
  localparam int NW = 2;
  localparam int NB = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [63:0]   src = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [0:0]    bank = '0;
  logic [7:0]    offs = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NB-1:0] irq;

  int total = 0, bad = 0;
  logic [31:0] exp_mask [NB][NW];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  lvl_irq_fanout #(.NUM_WORDS(NW), .NUM_BANKS(NB), .OFFS_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .bank_i(bank), .offs_i(offs), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq(input int b);
    logic r = 1'b0;
    for (int w = 0; w < NW; w++) r |= |(src[w*32 +: 32] & ~exp_mask[b][w]);
    return r;
  endfunction

  // driver: read, expected value goes to scoreboard
  task automatic rd(input int b, input int o, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; bank = 1'(b); offs = 8'(o);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wr(input int b, input int o, input logic [31:0] d);
    int idx = o >> 2;
    @(negedge clk);
    req = 1'b1; we = 1'b1; bank = 1'(b); offs = 8'(o); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    if (idx < 4 * NW) begin
      if (idx / NW == 2) exp_mask[b][idx % NW] |= d;
      if (idx / NW == 3) exp_mask[b][idx % NW] &= ~d;
    end
  endtask

  // monitor: compares registered read data one edge after the request
  always @(posedge clk) begin
    if (rst_n && req && !we) begin
      @(negedge clk);
      chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic chk_irq(input string tag);
    @(negedge clk);
    for (int b = 0; b < NB; b++) chk(32'(irq[b]), 32'(exp_irq(b)), tag);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    for (int b = 0; b < NB; b++) for (int w = 0; w < NW; w++) exp_mask[b][w] = '1;
    repeat (3) @(negedge clk);
    chk(32'(irq), 0, "R1 irq after reset");
    chk(rdata, 0, "R1 rdata after reset");
    rst_n = 1'b1;
    rd(0, 8,  32'hffff_ffff, "R1 bank0 mask w0");
    rd(1, 12, 32'hffff_ffff, "R1 bank1 mask w1");

    src = 64'h0000_0020_8000_0001;
    rd(0, 0, 32'h8000_0001, "R7 raw w0 masked");
    rd(1, 4, 32'h0000_0020, "R7 raw w1 masked");
    chk_irq("R5 all masked");

    wr(0, 28, 32'h0000_0020);
    chk_irq("R5 R6 unmask b0 w1 bit5");
    chk(32'(irq), 2'b01, "R6 only bank0 fires");
    rd(0, 12, 32'hffff_ffdf, "R4 bank0 mask w1");
    rd(1, 12, 32'hffff_ffff, "R6 bank1 untouched");
    rd(0, 4, 32'h0000_0020, "R7 raw ignores mask");

    src = 64'h0000_0000_8000_0001;
    chk_irq("R5 level drop");
    chk(32'(irq), 0, "R5 irq follows level");
    src = 64'h0000_0020_8000_0001;
    chk_irq("R5 level return");

    wr(0, 20, 32'h0000_0020);
    chk_irq("R3 remask");
    rd(0, 12, 32'hffff_ffff, "R3 bank0 mask w1");

    wr(1, 24, 32'h8000_0000);
    chk_irq("R6 bank1 w0 bit31");
    chk(32'(irq), 2'b10, "R6 only bank1 fires");
    wr(1, 24, 32'h0000_0010);
    rd(1, 8, 32'h7fff_ffef, "R4 partial clear");

    wr(1, 0, 32'h0);
    wr(1, 8, 32'hffff_ffff);
    rd(1, 8, 32'h7fff_ffef, "R8 ro writes ignored");
    rd(1, 16, 32'h0, "R8 set group reads zero");
    rd(1, 28, 32'h0, "R8 clear group reads zero");

    wr(1, 32, 32'hffff_ffff);
    wr(1, 60, 32'hffff_ffff);
    rd(1, 8, 32'h7fff_ffef, "R9 oor writes ignored");
    rd(1, 32, 32'h0, "R9 oor read 32");
    rd(1, 252, 32'h0, "R9 oor read 252");
    chk_irq("R9 irq unchanged");

    rd(1, 11, 32'h7fff_ffef, "R2 byte lanes ignored");
    rd(0, 1, 32'h8000_0001, "R2 offset 1 is raw w0");

    // R5 latency: irq registers one edge after source change
    wr(1, 24, 32'hffff_ffff);
    src = '0;
    chk_irq("R5 cleared src");
    @(negedge clk);
    src = 64'h1;
    #1 chk(32'(irq), 0, "R5 not combinational");
    chk_irq("R5 one-edge latency");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule